// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Slave

This block is a serial-bus target that sits on a two-wire I2C bus and holds a small bank of 8-bit control registers. It decodes bus conditions from an oversampled copy of SCL and SDA. It answers only to its own 7-bit address and pulls SDA low through an open-drain enable to acknowledge bytes or to send read data. The register contents are presented in parallel on `regsOut` so that neighbouring logic can use them as control settings.

A write transfer carries a register pointer and then exactly one data byte. A read transfer returns the register that the stored pointer selects. The pointer is held in a register that is only changed by a pointer byte. A master can therefore load it, end the transfer with STOP, talk to other devices, and later fetch the byte with a read-only transfer. It can also load the pointer and read straight away after a repeated START. The pointer never advances on its own.

Top module: `i2c_ptr_regslave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal the device address (default 7'h37, so 8'h6E writes and 8'h6F reads). Any other address gets no acknowledge. The slave then ignores the bus until the next START or repeated START, and the stored pointer keeps its value.
- R2: In a write transfer the slave acknowledges the address, the pointer byte and one data byte, and the data byte appears in the selected register. Register k occupies `regsOut[8k+7:8k]`.
- R3: A repeated START after the pointer byte, followed by the read address, returns the byte of the selected register MSB first. The slave acknowledges the read address.
- R4: A pointer loaded by a write transfer that ends at STOP is kept across that STOP and across traffic addressed to other devices. A later read-only transfer returns the register that pointer selects.
- R5: The pointer never moves by itself. A second data byte in one write transfer is not acknowledged and changes no register. When the master acknowledges a read byte, the same register is sent again.
- R6: A pointer value of 4 or more is acknowledged together with its data byte. A write through such a pointer changes no register, and a read through it returns 8'h00.
- R7: After reset all registers are 8'h00, the pointer is 0 and SDA is released. A read-only transfer then returns 8'h00.
- R8: Transfers work at both fast-mode and standard-mode bit timing, provided the system clock runs at least eight times the SCL rate with a two-stage input synchroniser. START is SDA falling while SCL is high. STOP is SDA rising while SCL is high.
- R9: The slave releases SDA (`sdaOe` low) once a STOP has been seen, and it never drives SDA while it is idle or ignoring the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | SCL level as seen on the bus |
| sdaIn | input | 1 | SDA level as seen on the bus |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regsOut | output | NUM_REGS*8 | Register bank contents, register k in bits [8k+7:8k] |

## Verification
The bench goes after the pointer's lifetime. It loads a pointer, ends with STOP, runs a transfer to a foreign address, and then reads. A design that cleared or re-captured the pointer on STOP or on a foreign address would return the wrong register. It sends an extra data byte in one write and acknowledges read bytes. A design that auto-increments would write a neighbouring register or stream the next register instead of repeating. It also uses out-of-range pointers, where an index that wraps would corrupt register 2 and read back non-zero data. It repeats the transfers at standard-mode timing, where a slave that counted SCL edges wrongly at a slower rate would lose its acknowledge slots.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_DATA,
    ST_READ,
    ST_WAIT
  } ctrlState_t;

  // Strobes issued by the control FSM to the datapath, one cycle wide.
  typedef struct packed {
    logic shiftIn;
    logic ptrLoad;
    logic regWrite;
    logic ackOn;
    logic txLoad;
    logic txShift;
    logic sdaRelease;
  } dpStrobe_t;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sclPipe;
  logic [MSB:0] sdaPipe;
  logic sclS;
  logic sclD;
  logic sdaD;

  // Idle bus is high, so the pipes reset to ones to avoid a false edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[MSB-1:0], sclIn};
      sdaPipe <= {sdaPipe[MSB-1:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclPipe[MSB];
  assign sdaS     = sdaPipe[MSB];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sdaS,
  input  logic      addrMatch,
  input  logic      rwBit,
  output dpStrobe_t stb
);

  localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);
  localparam logic [3:0] END_SLOT = 4'(BYTE_W + 1);

  ctrlState_t state, stateNxt;
  logic [3:0] bitCnt, bitCntNxt;
  logic       masterAck, masterAckNxt;

  always_comb begin
    stb          = '0;
    stateNxt     = state;
    bitCntNxt    = bitCnt;
    masterAckNxt = masterAck;
    if (stopDet) begin
      stateNxt       = ST_IDLE;
      stb.sdaRelease = 1'b1;
    end else if (startDet) begin
      stateNxt       = ST_ADDR;
      bitCntNxt      = '0;
      stb.sdaRelease = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_DATA: begin
          if (sclRise) begin
            if (bitCnt < ACK_SLOT) stb.shiftIn = 1'b1;
            bitCntNxt = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == ACK_SLOT) begin
            if (state == ST_ADDR) begin
              if (addrMatch) stb.ackOn = 1'b1;
              else           stateNxt  = ST_WAIT;
            end else begin
              stb.ackOn = 1'b1;
              if (state == ST_PTR) stb.ptrLoad  = 1'b1;
              else                 stb.regWrite = 1'b1;
            end
          end else if (sclFall && bitCnt == END_SLOT) begin
            bitCntNxt = '0;
            if (state == ST_ADDR && rwBit) begin
              stateNxt   = ST_READ;
              stb.txLoad = 1'b1;
            end else begin
              stb.sdaRelease = 1'b1;
              if (state == ST_ADDR)     stateNxt = ST_PTR;
              else if (state == ST_PTR) stateNxt = ST_DATA;
              else                      stateNxt = ST_WAIT;
            end
          end
        end
        ST_READ: begin
          if (sclRise) begin
            if (bitCnt == ACK_SLOT) masterAckNxt = ~sdaS;
            bitCntNxt = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt != 4'd0 && bitCnt < ACK_SLOT) begin
              stb.txShift = 1'b1;
            end else if (bitCnt == ACK_SLOT) begin
              stb.sdaRelease = 1'b1;
            end else if (bitCnt == END_SLOT) begin
              bitCntNxt = '0;
              if (masterAck) begin
                stb.txLoad = 1'b1;
              end else begin
                stateNxt       = ST_WAIT;
                stb.sdaRelease = 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateNxt;
      bitCnt    <= bitCntNxt;
      masterAck <= masterAckNxt;
    end
  end

  // R1: an acknowledge of the address byte requires a datapath address match
  p_ack_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackOn && state == ST_ADDR) |-> addrMatch);

  // R9: nothing that could drive SDA or change a register leaves an idle FSM
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_WAIT) |->
      !(stb.ackOn || stb.txLoad || stb.txShift || stb.regWrite));

endmodule

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int         NUM_REGS = 4,
  parameter logic [6:0] DEV_ADDR = 7'h37
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  stb,
  input  logic                       sdaS,
  output logic                       addrMatch,
  output logic                       rwBit,
  output logic                       sdaOe,
  output logic [NUM_REGS*BYTE_W-1:0] regsOut
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [BYTE_W-1:0] REG_LIMIT = BYTE_W'(NUM_REGS);

  logic [BYTE_W-1:0]                rxSh;
  logic [BYTE_W-1:0]                ptr;
  logic [NUM_REGS-1:0][BYTE_W-1:0]  regBank;
  logic [BYTE_W-2:0]                txSh;
  logic                             ptrValid;
  logic [BYTE_W-1:0]                rdByte;

  assign ptrValid  = ptr < REG_LIMIT;
  assign rdByte    = ptrValid ? regBank[ptr[IDX_W-1:0]] : '0;
  assign addrMatch = rxSh[BYTE_W-1:1] == DEV_ADDR;
  assign rwBit     = rxSh[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh <= '0;
      ptr  <= '0;
    end else begin
      if (stb.shiftIn) rxSh <= {rxSh[BYTE_W-2:0], sdaS};
      if (stb.ptrLoad) ptr  <= rxSh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regBank <= '0;
    end else if (stb.regWrite && ptrValid) begin
      regBank[ptr[IDX_W-1:0]] <= rxSh;
    end
  end

  // Outgoing byte: MSB goes straight to the pad enable, the rest waits here.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh  <= '0;
      sdaOe <= 1'b0;
    end else if (stb.txLoad) begin
      txSh  <= rdByte[BYTE_W-2:0];
      sdaOe <= ~rdByte[BYTE_W-1];
    end else if (stb.txShift) begin
      txSh  <= {txSh[BYTE_W-3:0], 1'b0};
      sdaOe <= ~txSh[BYTE_W-2];
    end else if (stb.ackOn) begin
      sdaOe <= 1'b1;
    end else if (stb.sdaRelease) begin
      sdaOe <= 1'b0;
    end
  end

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_out
    assign regsOut[gi*BYTE_W +: BYTE_W] = regBank[gi];
  end

  // R4: the pointer changes only on an explicit pointer byte
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ptrLoad |=> $stable(ptr));

  // R6: a write through an out-of-range pointer leaves the bank untouched
  p_bad_ptr_no_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.regWrite && !ptrValid) |=> $stable(regBank));

  // R6: a read through an out-of-range pointer starts with a driven zero
  p_bad_ptr_reads_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.txLoad && !ptrValid) |=> sdaOe);

endmodule

// File: rtl/i2c_ptr_regslave.sv
module i2c_ptr_regslave
  import i2cs_pkg::*;
#(
  parameter int         NUM_REGS    = 4,
  parameter logic [6:0] DEV_ADDR    = 7'h37,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  output logic                       sdaOe,
  output logic [NUM_REGS*BYTE_W-1:0] regsOut
);

  logic      sdaS;
  logic      sclRise;
  logic      sclFall;
  logic      startDet;
  logic      stopDet;
  logic      addrMatch;
  logic      rwBit;
  dpStrobe_t stb;

  i2cs_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sdaS     (sdaS),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet)
  );

  i2cs_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startDet  (startDet),
    .stopDet   (stopDet),
    .sdaS      (sdaS),
    .addrMatch (addrMatch),
    .rwBit     (rwBit),
    .stb       (stb)
  );

  i2cs_datapath #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .sdaS      (sdaS),
    .addrMatch (addrMatch),
    .rwBit     (rwBit),
    .sdaOe     (sdaOe),
    .regsOut   (regsOut)
  );

endmodule

// File: tb/i2c_ptr_regslave_test.sv
module i2c_ptr_regslave_test;

  localparam int CLK_PERIOD = 62;
  localparam int FAST_Q     = 10;
  localparam int STD_Q      = 40;
  localparam int WATCHDOG   = 190000;
  localparam logic [7:0] WR_ADDR = 8'h6E;
  localparam logic [7:0] RD_ADDR = 8'h6F;
  localparam logic [15:0] VEC [4] = '{16'h00A5, 16'h013C, 16'h02FF, 16'h0381};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclDrv = 1'b1;
  logic        sdaDrv = 1'b1;
  logic        sdaOe;
  logic [31:0] regsOut;
  logic        sdaBus;
  logic [7:0]  expRegs [4];
  int          q = FAST_Q;
  int          nRun = 0;
  int          nFail = 0;

  assign sdaBus = sdaDrv & ~sdaOe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_ptr_regslave uut (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclDrv),
    .sdaIn   (sdaBus),
    .sdaOe   (sdaOe),
    .regsOut (regsOut)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expVec();
    return {expRegs[3], expRegs[2], expRegs[1], expRegs[0]};
  endfunction

  task automatic startCond(input bit rep);
    if (rep) begin
      sdaDrv = 1'b1; waitClk(q);
      sclDrv = 1'b1; waitClk(q);
    end else begin
      waitClk(q);
    end
    sdaDrv = 1'b0; waitClk(q);
    sclDrv = 1'b0; waitClk(q);
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0; waitClk(q);
    sclDrv = 1'b1; waitClk(q);
    sdaDrv = 1'b1; waitClk(2 * q);
    chk("R9", "SDA released after STOP", {31'd0, sdaOe}, 32'd0);
  endtask

  task automatic sendBit(input logic b);
    sdaDrv = b;    waitClk(q);
    sclDrv = 1'b1; waitClk(2 * q);
    sclDrv = 1'b0; waitClk(q);
  endtask

  task automatic recvBit(output logic b);
    sdaDrv = 1'b1; waitClk(q);
    sclDrv = 1'b1; waitClk(q);
    b = sdaBus;    waitClk(q);
    sclDrv = 1'b0; waitClk(q);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(output logic [7:0] d, input logic giveAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      d[i] = b;
    end
    sendBit(~giveAck);
  endtask

  task automatic writeReg(input string req, input logic [7:0] p, input logic [7:0] d);
    logic a;
    startCond(0);
    sendByte(WR_ADDR, a); chk(req, "write address ack", {31'd0, a}, 32'd1);
    sendByte(p, a);       chk(req, "pointer ack", {31'd0, a}, 32'd1);
    sendByte(d, a);       chk(req, "data ack", {31'd0, a}, 32'd1);
    stopCond();
  endtask

  task automatic setPtr(input string req, input logic [7:0] p);
    logic a;
    startCond(0);
    sendByte(WR_ADDR, a); chk(req, "write address ack", {31'd0, a}, 32'd1);
    sendByte(p, a);       chk(req, "pointer ack", {31'd0, a}, 32'd1);
    stopCond();
  endtask

  task automatic readCombined(input string req, input logic [7:0] p, output logic [7:0] d);
    logic a;
    startCond(0);
    sendByte(WR_ADDR, a); chk(req, "write address ack", {31'd0, a}, 32'd1);
    sendByte(p, a);       chk(req, "pointer ack", {31'd0, a}, 32'd1);
    startCond(1);
    sendByte(RD_ADDR, a); chk(req, "read address ack", {31'd0, a}, 32'd1);
    recvByte(d, 1'b0);
    stopCond();
  endtask

  task automatic readOnly(input string req, output logic [7:0] d);
    logic a;
    startCond(0);
    sendByte(RD_ADDR, a); chk(req, "read address ack", {31'd0, a}, 32'd1);
    recvByte(d, 1'b0);
    stopCond();
  endtask

  initial begin
    waitClk(WATCHDOG);
    nFail++;
    $display("FAIL watchdog: run did not finish in %0d cycles", WATCHDOG);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic a;
    for (int i = 0; i < 4; i++) expRegs[i] = 8'h00;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R7: reset state at the ports and a read through the reset pointer
    chk("R7", "sdaOe after reset", {31'd0, sdaOe}, 32'd0);
    chk("R7", "registers after reset", regsOut, 32'd0);
    readOnly("R7", d);
    chk("R7", "read with reset pointer", {24'd0, d}, 32'd0);

    // R2 R3 R8: vector table, fast-mode write then combined read
    for (int i = 0; i < 4; i++) begin
      writeReg("R2", VEC[i][15:8], VEC[i][7:0]);
      expRegs[VEC[i][9:8]] = VEC[i][7:0];
      chk("R2", "register bank after write", regsOut, expVec());
      readCombined("R3", VEC[i][15:8], d);
      chk("R3", "combined read data", {24'd0, d}, {24'd0, VEC[i][7:0]});
    end

    // R4 R1: pointer survives STOP and a foreign-address transfer
    setPtr("R4", 8'h01);
    startCond(0);
    sendByte(8'hA0, a); chk("R1", "foreign address not acked", {31'd0, a}, 32'd0);
    sendByte(8'h02, a); chk("R1", "foreign byte not acked", {31'd0, a}, 32'd0);
    stopCond();
    chk("R1", "foreign write leaves bank", regsOut, expVec());
    readOnly("R4", d);
    chk("R4", "stop-separated read", {24'd0, d}, {24'd0, expRegs[1]});

    // R5: a second data byte in one write is refused
    startCond(0);
    sendByte(WR_ADDR, a); chk("R5", "address ack", {31'd0, a}, 32'd1);
    sendByte(8'h00, a);   chk("R5", "pointer ack", {31'd0, a}, 32'd1);
    sendByte(8'h11, a);   chk("R5", "first data ack", {31'd0, a}, 32'd1);
    sendByte(8'h22, a);   chk("R5", "second data not acked", {31'd0, a}, 32'd0);
    stopCond();
    expRegs[0] = 8'h11;
    chk("R5", "only addressed register written", regsOut, expVec());

    // R5: master ACK repeats the same register
    setPtr("R5", 8'h02);
    startCond(0);
    sendByte(RD_ADDR, a); chk("R5", "read address ack", {31'd0, a}, 32'd1);
    recvByte(d, 1'b1); chk("R5", "read byte 1", {24'd0, d}, {24'd0, expRegs[2]});
    recvByte(d, 1'b1); chk("R5", "read byte 2 repeats", {24'd0, d}, {24'd0, expRegs[2]});
    recvByte(d, 1'b0); chk("R5", "read byte 3 repeats", {24'd0, d}, {24'd0, expRegs[2]});
    stopCond();

    // R6: out-of-range pointer
    writeReg("R6", 8'h06, 8'hAA);
    chk("R6", "write via bad pointer ignored", regsOut, expVec());
    readCombined("R6", 8'h04, d);
    chk("R6", "read via bad pointer", {24'd0, d}, 32'd0);

    // R8: standard-mode timing
    q = STD_Q;
    writeReg("R8", 8'h03, 8'h5A);
    expRegs[3] = 8'h5A;
    chk("R8", "standard-mode write", regsOut, expVec());
    setPtr("R8", 8'h03);
    readOnly("R8", d);
    chk("R8", "standard-mode read", {24'd0, d}, 32'h5A);
    q = FAST_Q;

    waitClk(10);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule